// File: doc/BRIEF.md
# Masked-Write GPIO Port Register File

This block holds the control state of a single eight-pin general-purpose I/O port and presents it on a simple memory-mapped read/write bus. Three writable per-pin registers set the pin's mode (GPIO versus alternate function), whether it is driven, and the level it drives. A read-only register returns the synchronised pad levels. The synchronised levels also go out to the interrupt logic, which sits in a separate block.

Each writable register has an alias located a fixed distance above it. A write to the alias treats the upper byte of the write data as a per-pin write mask. Software can then set or clear one pin in a single bus write, with no read-modify-write and no lock. A pin is driven only while it is both in GPIO mode and output-enabled. When a pin is not in GPIO mode, the `pad_gpio` output hands the pin to its alternate function.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, every register reads 0, and `pad_out`, `pad_oe` and `pad_gpio` are all 0.
- R2: A plain write to the mode register (offset 0x00), the drive register (0x10) or the level register (0x20) replaces all 8 bits with write-data bits [7:0] at the next clock edge.
- R3: A write to an alias (mode 0x80, drive 0x90, level 0xA0) changes register bit p only when write-data bit 8+p is 1. When it changes, bit p takes write-data bit p.
- R4: An alias write whose mask byte (bits [15:8]) is zero leaves the register unchanged.
- R5: `pad_oe[p]` is 1 exactly when mode bit p and drive bit p are both 1. `pad_out` always equals the level register.
- R6: `pad_gpio` equals the mode register, so a 0 bit hands that pin to its alternate function.
- R7: A read of offset 0x30 returns the pad levels two clock edges after they are sampled on `pad_in`. Writes to 0x30 change nothing.
- R8: Reads of the three writable registers return their 8 bits in [7:0], with bits [31:8] zero.
- R9: Reads of any other offset, including the alias offsets, return 0. Writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte offset within the port |
| bus_wdata | input | 32 | Write data; bits [15:8] are the mask on alias writes |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 8 | Raw pad levels |
| pad_out | output | 8 | Level driven onto each pad |
| pad_oe | output | 8 | Per-pad drive enable |
| pad_gpio | output | 8 | Per-pad GPIO-mode select; 0 means alternate function |
| pin_sync | output | 8 | Synchronised pad levels for the interrupt logic |

## Verification
The hardest case to reach is a masked write on top of a register that already holds an arbitrary pattern. In that case the kept bits and the loaded bits both carry information. The bench first loads each register through its plain offset and then sweeps many data and mask combinations through the alias. It folds each result into a running model, so that every alias write starts from a non-trivial prior value. It then confirms the register by readback and on the pad outputs.

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int PINS = 8,
  parameter int AW = 8,
  parameter logic [7:0] OFS_MODE = 8'h00,
  parameter logic [7:0] OFS_DRIVE = 8'h10,
  parameter logic [7:0] OFS_LEVEL = 8'h20,
  parameter logic [7:0] OFS_SENSE = 8'h30,
  parameter logic [7:0] OFS_ALIAS = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_gpio,
  output logic [PINS-1:0] pin_sync
);
  localparam logic [AW-1:0] A_MODE   = AW'(OFS_MODE);
  localparam logic [AW-1:0] A_DRIVE  = AW'(OFS_DRIVE);
  localparam logic [AW-1:0] A_LEVEL  = AW'(OFS_LEVEL);
  localparam logic [AW-1:0] A_SENSE  = AW'(OFS_SENSE);
  localparam logic [AW-1:0] A_MODE_M  = AW'(OFS_MODE + OFS_ALIAS);
  localparam logic [AW-1:0] A_DRIVE_M = AW'(OFS_DRIVE + OFS_ALIAS);
  localparam logic [AW-1:0] A_LEVEL_M = AW'(OFS_LEVEL + OFS_ALIAS);
  localparam int PAD = 32 - PINS;

  logic [PINS-1:0] mode_q, drive_q, level_q, sync1_q, sync2_q;
  logic [PINS-1:0] wval, wmsk;

  assign wval = bus_wdata[PINS-1:0];
  assign wmsk = bus_wdata[8 +: PINS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      drive_q <= '0;
      level_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_MODE)    mode_q  <= wval;
      if (bus_addr == A_MODE_M)  mode_q  <= (mode_q & ~wmsk) | (wval & wmsk);
      if (bus_addr == A_DRIVE)   drive_q <= wval;
      if (bus_addr == A_DRIVE_M) drive_q <= (drive_q & ~wmsk) | (wval & wmsk);
      if (bus_addr == A_LEVEL)   level_q <= wval;
      if (bus_addr == A_LEVEL_M) level_q <= (level_q & ~wmsk) | (wval & wmsk);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MODE:  bus_rdata = {{PAD{1'b0}}, mode_q};
      A_DRIVE: bus_rdata = {{PAD{1'b0}}, drive_q};
      A_LEVEL: bus_rdata = {{PAD{1'b0}}, level_q};
      A_SENSE: bus_rdata = {{PAD{1'b0}}, sync2_q};
      default: bus_rdata = '0;
    endcase
  end

  assign pad_out  = level_q;
  assign pad_gpio = mode_q;
  assign pad_oe   = mode_q & drive_q;
  assign pin_sync = sync2_q;

  a_r2_plain_level_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_LEVEL) |=> (pad_out == $past(bus_wdata[PINS-1:0])));

  a_r3_alias_keeps_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DRIVE_M) |=>
      (((drive_q ^ $past(drive_q)) & ~$past(bus_wdata[8 +: PINS])) == '0));

  a_r5_oe_needs_gpio: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~pad_gpio) == '0));

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(mode_q) && $stable(drive_q) && $stable(level_q)));
endmodule

// File: tb/test_gpio_port_regs.sv
module test_gpio_port_regs;
  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0, pad_in = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [7:0] pad_out, pad_oe, pad_gpio, pin_sync;
  logic [7:0] m_mode = 0, m_drive = 0, m_level = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_port_regs i_gpio_port_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_gpio(pad_gpio), .pin_sync(pin_sync));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic check_all(input string req);
    rd(req, 8'h00, {24'h0, m_mode});
    rd(req, 8'h10, {24'h0, m_drive});
    rd(req, 8'h20, {24'h0, m_level});
    chk({req, " pad_out R5"}, {24'h0, pad_out}, {24'h0, m_level});
    chk({req, " pad_oe R5"}, {24'h0, pad_oe}, {24'h0, m_mode & m_drive});
    chk({req, " pad_gpio R6"}, {24'h0, pad_gpio}, {24'h0, m_mode});
  endtask

  function automatic logic [7:0] merge(input logic [7:0] old, input logic [7:0] v, input logic [7:0] m);
    return (old & ~m) | (v & m);
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rd("R1 reset sense", 8'h30, 32'h0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 256; i++) begin
      logic [7:0] v;
      v = 8'(i);
      wr(8'h00, {16'hFFFF, 8'h00, v}); m_mode = v;
      wr(8'h10, {16'hA5A5, 8'hFF, ~v}); m_drive = ~v;
      wr(8'h20, {24'h123456, v ^ 8'h5A}); m_level = v ^ 8'h5A;
      check_all("R2 R8 plain sweep");
    end

    for (int i = 0; i < 256; i++) begin
      logic [7:0] v, m;
      v = 8'((i * 37 + 11) & 255);
      m = 8'((i * 91 + 5) & 255);
      wr(8'h80, {16'h0, m, v}); m_mode = merge(m_mode, v, m);
      wr(8'h90, {16'hFFFF, m ^ 8'h3C, ~v}); m_drive = merge(m_drive, ~v, m ^ 8'h3C);
      wr(8'hA0, {16'h0, ~m, v}); m_level = merge(m_level, v, ~m);
      check_all("R3 alias sweep");
    end

    for (int p = 0; p < 8; p++) begin
      wr(8'h90, {16'h0, 8'(1 << p), 8'hFF}); m_drive = merge(m_drive, 8'hFF, 8'(1 << p));
      wr(8'h80, {16'h0, 8'(1 << p), 8'h00}); m_mode = merge(m_mode, 8'h00, 8'(1 << p));
      check_all("R3 R5 single pin");
    end

    wr(8'h80, {16'h0, 8'h00, 8'hFF});
    wr(8'h90, {16'hFFFF, 8'h00, 8'hAA});
    wr(8'hA0, {16'h0, 8'h00, ~m_level});
    check_all("R4 zero mask");

    foreach (m_mode[j]) begin end
    begin
      logic [7:0] skip [0:8];
      skip = '{8'h30, 8'h40, 8'h50, 8'h60, 8'h70, 8'hB0, 8'hF0, 8'h01, 8'h81};
      for (int k = 0; k < 9; k++) begin
        wr(skip[k], 32'hFFFF_FFFF);
        check_all("R9 R7 ignored write");
        rd("R9 unmapped read", skip[k] == 8'h30 ? 8'h40 : skip[k], 32'h0);
      end
      rd("R9 alias read", 8'h80, 32'h0);
      rd("R9 alias read", 8'h90, 32'h0);
      rd("R9 alias read", 8'hA0, 32'h0);
    end

    for (int i = 0; i < 256; i++) begin
      logic [7:0] prev;
      prev = pad_in;
      @(negedge clk);
      pad_in = 8'(i * 29 + 3);
      @(negedge clk);
      rd("R7 sense after one edge", 8'h30, {24'h0, prev});
      @(negedge clk);
      rd("R7 sense after two edges", 8'h30, {24'h0, pad_in});
      chk("R7 pin_sync", {24'h0, pin_sync}, {24'h0, pad_in});
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule